// File: doc/BRIEF.md
# Memory Error Logging Unit

This unit gathers error events flagged by the SEC-DED checkers of three memories: SRAM, scratchpad and flash. Each checker raises a one-cycle strobe with the faulting address and a severity flag. A set flag means a detected double-bit error that cannot be corrected. A clear flag means a single-bit error that was corrected. The unit keeps six small address logs, one for each pair of memory and severity. A status word records the class and the source of the most recent event.

The unit never interrupts a processor. For every newly logged event it raises a one-cycle pulse on one of six fault lines, one for each pair of memory and severity. An external fault collection unit receives these lines and decides on interrupts and reactions. Software reads the logs and the status through a small register port. It frees a log slot by writing 1 to that slot's valid bit.

Top module: `mel_log`

## Requirements
- R1: An event from source s (0 SRAM, 1 scratchpad, 2 flash) with severity flag u (1 uncorrectable) goes into log t = 2*s + u. Register map: status at 0x00; the control word of log t at 0x08+t, with valid bits in [3:0] and overflow in bit 16; entry e of log t at 0x20+4*t+e, with the stored address in [15:0] and the valid bit in bit 31; any other address reads 0.
- R2: A new address is written into the lowest-numbered free slot of its log and that slot's valid bit is set. Both are visible one cycle after the strobe.
- R3: An event whose address matches a valid slot of the same log adds no entry and raises no fault pulse.
- R4: An event that meets a full log is dropped and sets that log's overflow bit. The overflow bit stays set until reset.
- R5: Writing 1 to a valid bit in a control word clears that slot. Writing 0 leaves the slot unchanged. A freed slot is reused by later events.
- R6: Fault outputs fault_corr[s] and fault_uncorr[s] pulse high for exactly one cycle, in the cycle after an event that creates a new entry. They pulse for nothing else.
- R7: Strobes from several sources in the same cycle are all logged. The status then describes the highest-numbered source among them (SRAM, then scratchpad, then flash).
- R8: Status bit 0 holds the severity of the latest event, bits [2:1] its source and bit 3 is set once any event has occurred. Every event updates the status, including events that are deduplicated or dropped.
- R9: After reset all logs, overflow bits, status and fault lines are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| err_valid | input | 3 | Error strobe per source (bit 0 SRAM, 1 scratchpad, 2 flash) |
| err_uncorr | input | 3 | Severity per source, 1 = uncorrectable |
| err_addr | input | 48 | Faulting address per source, 16 bits each, source 0 in the low bits |
| reg_addr | input | 6 | Register address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| fault_corr | output | 3 | One-cycle forward pulse per source for a new correctable entry |
| fault_uncorr | output | 3 | One-cycle forward pulse per source for a new uncorrectable entry |

## Verification
The hardest state to reach is a full log with its overflow bit set, followed by a software clear of a single middle slot and a new event. That event has to land in the freed slot, while the overflow bit stays set and the surviving slots stay intact. The stimulus fills the SRAM correctable log with distinct addresses, sends one more address to trip the overflow, and repeats an old address to exercise deduplication. It then clears slot 1 and sends a fresh address. A final cycle strobes all three sources at once with mixed severities to check parallel logging and the status priority.

// File: rtl/mel_pkg.sv
package mel_pkg;
    localparam int N_SRC      = 3;
    localparam int N_TAB      = 2 * N_SRC;
    localparam int RA_W       = 6;
    localparam int DATA_W     = 32;
    localparam int CTRL_BASE  = 8;
    localparam int ENT_BASE   = 32;
    localparam int OVF_BIT    = 16;

    typedef struct packed {
        logic       seen;
        logic [1:0] src;
        logic       sev;
    } mel_stat_t;
endpackage

// File: rtl/mel_table.sv
module mel_table #(
    parameter int ENTRIES = 4,
    parameter int ADDR_W  = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ev_valid,
    input  logic [ADDR_W-1:0]         ev_addr,
    input  logic [ENTRIES-1:0]        clr_mask,
    output logic [ENTRIES-1:0]        valid_o,
    output logic                      ovf_o,
    output logic [ENTRIES*ADDR_W-1:0] addr_o,
    output logic                      logged_o
);
    typedef struct packed {
        logic [ENTRIES-1:0]             valid;
        logic [ENTRIES-1:0][ADDR_W-1:0] addr;
        logic                           ovf;
        logic                           logged;
    } tab_t;

    tab_t s_d, s_q;

    always_comb begin
        logic             hit;
        logic             found;
        logic [ENTRIES-1:0] free_oh;
        s_d        = s_q;
        s_d.logged = 1'b0;
        s_d.valid  = s_q.valid & ~clr_mask;
        hit        = 1'b0;
        found      = 1'b0;
        free_oh    = '0;
        for (int e = 0; e < ENTRIES; e++) begin
            if (s_d.valid[e] && s_q.addr[e] == ev_addr) hit = 1'b1;
            if (!s_d.valid[e] && !found) begin
                free_oh[e] = 1'b1;
                found      = 1'b1;
            end
        end
        if (ev_valid && !hit) begin
            if (found) begin
                for (int e = 0; e < ENTRIES; e++) begin
                    if (free_oh[e]) begin
                        s_d.valid[e] = 1'b1;
                        s_d.addr[e]  = ev_addr;
                    end
                end
                s_d.logged = 1'b1;
            end else begin
                s_d.ovf = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign valid_o  = s_q.valid;
    assign ovf_o    = s_q.ovf;
    assign addr_o   = s_q.addr;
    assign logged_o = s_q.logged;
endmodule

// File: rtl/mel_rdmux.sv
module mel_rdmux
    import mel_pkg::*;
#(
    parameter int ENTRIES = 4,
    parameter int ADDR_W  = 16
) (
    input  logic [RA_W-1:0]                 reg_addr,
    input  mel_stat_t                       stat,
    input  logic [N_TAB*ENTRIES-1:0]        valid_all,
    input  logic [N_TAB-1:0]                ovf_all,
    input  logic [N_TAB*ENTRIES*ADDR_W-1:0] addr_all,
    output logic [DATA_W-1:0]               rdata
);
    always_comb begin
        rdata = '0;
        if (reg_addr == '0) rdata[3:0] = stat;
        for (int t = 0; t < N_TAB; t++) begin
            if (reg_addr == RA_W'(CTRL_BASE + t)) begin
                rdata[ENTRIES-1:0] = valid_all[t*ENTRIES +: ENTRIES];
                rdata[OVF_BIT]     = ovf_all[t];
            end
            for (int e = 0; e < ENTRIES; e++) begin
                if (reg_addr == RA_W'(ENT_BASE + t*ENTRIES + e)) begin
                    rdata[ADDR_W-1:0] = addr_all[(t*ENTRIES+e)*ADDR_W +: ADDR_W];
                    rdata[DATA_W-1]   = valid_all[t*ENTRIES + e];
                end
            end
        end
    end
endmodule

// File: rtl/mel_log.sv
module mel_log
    import mel_pkg::*;
#(
    parameter int ENTRIES = 4,
    parameter int ADDR_W  = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_SRC-1:0]          err_valid,
    input  logic [N_SRC-1:0]          err_uncorr,
    input  logic [N_SRC*ADDR_W-1:0]   err_addr,
    input  logic [RA_W-1:0]           reg_addr,
    input  logic                      reg_we,
    input  logic [DATA_W-1:0]         reg_wdata,
    output logic [DATA_W-1:0]         reg_rdata,
    output logic [N_SRC-1:0]          fault_corr,
    output logic [N_SRC-1:0]          fault_uncorr
);
    localparam int SLOTS = N_TAB * ENTRIES;

    mel_stat_t stat_d, stat_q;
    logic [SLOTS-1:0]        valid_all;
    logic [N_TAB-1:0]        ovf_all;
    logic [SLOTS*ADDR_W-1:0] addr_all;
    logic [N_TAB-1:0]        logged;

    always_comb begin
        stat_d = stat_q;
        for (int s = 0; s < N_SRC; s++) begin
            if (err_valid[s]) begin
                stat_d.seen = 1'b1;
                stat_d.src  = 2'(s);
                stat_d.sev  = err_uncorr[s];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end

    for (genvar t = 0; t < N_TAB; t++) begin : g_tab
        localparam int SRC = t / 2;
        localparam int SEV = t % 2;
        logic [ENTRIES-1:0] clr;
        logic               ev;
        assign clr = (reg_we && reg_addr == RA_W'(CTRL_BASE + t))
                     ? reg_wdata[ENTRIES-1:0] : '0;
        assign ev  = err_valid[SRC] && (err_uncorr[SRC] == 1'(SEV));
        mel_table #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_tab (
            .clk      (clk),
            .rst_n    (rst_n),
            .ev_valid (ev),
            .ev_addr  (err_addr[SRC*ADDR_W +: ADDR_W]),
            .clr_mask (clr),
            .valid_o  (valid_all[t*ENTRIES +: ENTRIES]),
            .ovf_o    (ovf_all[t]),
            .addr_o   (addr_all[t*ENTRIES*ADDR_W +: ENTRIES*ADDR_W]),
            .logged_o (logged[t])
        );
    end

    for (genvar s = 0; s < N_SRC; s++) begin : g_fwd
        assign fault_corr[s]   = logged[2*s];
        assign fault_uncorr[s] = logged[2*s+1];
    end

    mel_rdmux #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_rd (
        .reg_addr  (reg_addr),
        .stat      (stat_q),
        .valid_all (valid_all),
        .ovf_all   (ovf_all),
        .addr_all  (addr_all),
        .rdata     (reg_rdata)
    );
endmodule

// File: rtl/mel_chk.sv
module mel_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] err_valid,
    input logic [2:0] err_uncorr,
    input logic [2:0] fault_corr,
    input logic [2:0] fault_uncorr,
    input logic [3:0] stat_q,
    input logic [5:0] ovf_all
);
    AST_CORR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_corr & ~$past(err_valid & ~err_uncorr)) == 3'b000); // R6
    AST_UNC_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_uncorr & ~$past(err_valid & err_uncorr)) == 3'b000); // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid == 3'b000 |=> (fault_corr | fault_uncorr) == 3'b000); // R6
    AST_SEV_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_corr & fault_uncorr) == 3'b000); // R1
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_all != 6'b0 |=> (ovf_all & $past(ovf_all)) == $past(ovf_all)); // R4
    AST_LAST_FLASH: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid[2] |=> stat_q[3] && stat_q[2:1] == 2'd2 && stat_q[0] == $past(err_uncorr[2])); // R7
endmodule

bind mel_log mel_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .err_valid    (err_valid),
    .err_uncorr   (err_uncorr),
    .fault_corr   (fault_corr),
    .fault_uncorr (fault_uncorr),
    .stat_q       (stat_q),
    .ovf_all      (ovf_all)
);

// File: tb/sim_mel_log.sv
module sim_mel_log;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  err_valid = '0;
    logic [2:0]  err_uncorr = '0;
    logic [47:0] err_addr = '0;
    logic [5:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [2:0]  fault_corr, fault_uncorr;

    int total = 0;
    int bad = 0;
    bit done = 0;
    int expq[$];

    logic        m_v [6][4];
    logic [15:0] m_a [6][4];
    logic        m_o [6];
    logic [3:0]  m_st;

    always #10 clk = ~clk;

    mel_log u0 (.*);

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // monitor: pops expected forward pulses in source order
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int s = 0; s < 3; s++) begin
                for (int u = 0; u < 2; u++) begin
                    if ((u == 0 ? fault_corr[s] : fault_uncorr[s]) === 1'b1) begin
                        if (expq.size() == 0) chk("R6 unexpected pulse", 32'(s*2+u), 32'hFFFF_FFFF);
                        else chk("R6 pulse line", 32'(s*2+u), 32'(expq.pop_front()));
                    end
                end
            end
        end
    end

    task automatic ev(input logic [2:0] v, input logic [2:0] u,
                      input logic [15:0] a0, input logic [15:0] a1, input logic [15:0] a2);
        logic [15:0] a [3];
        a[0] = a0; a[1] = a1; a[2] = a2;
        @(negedge clk);
        err_valid = v; err_uncorr = u; err_addr = {a2, a1, a0};
        for (int s = 0; s < 3; s++) begin
            if (v[s]) begin
                int t; bit hit; int fr;
                t = s*2 + int'(u[s]); hit = 0; fr = -1;
                for (int e = 0; e < 4; e++) begin
                    if (m_v[t][e] && m_a[t][e] == a[s]) hit = 1;
                    if (!m_v[t][e] && fr < 0) fr = e;
                end
                if (!hit) begin
                    if (fr >= 0) begin
                        m_v[t][fr] = 1; m_a[t][fr] = a[s]; expq.push_back(t);
                    end else m_o[t] = 1;
                end
                m_st = {1'b1, 2'(s), u[s]};
            end
        end
        @(negedge clk);
        err_valid = '0;
    endtask

    task automatic wr(input logic [5:0] ad, input logic [31:0] d);
        @(negedge clk);
        reg_addr = ad; reg_wdata = d; reg_we = 1'b1;
        if (ad >= 8 && ad < 14)
            for (int e = 0; e < 4; e++) if (d[e]) m_v[ad-8][e] = 0;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] ad, output logic [31:0] d);
        reg_addr = ad; #1; d = reg_rdata;
    endtask

    task automatic chk_tab(input string req, input int t);
        logic [31:0] d, x;
        rd(6'(8 + t), d);
        x = '0;
        for (int e = 0; e < 4; e++) x[e] = m_v[t][e];
        x[16] = m_o[t];
        chk({req, " ctrl"}, d, x);
        for (int e = 0; e < 4; e++) begin
            rd(6'(32 + 4*t + e), d);
            chk({req, " entry"}, d, {m_v[t][e], 15'b0, m_a[t][e]});
        end
    endtask

    task automatic chk_stat(input string req);
        logic [31:0] d;
        rd(6'd0, d);
        chk(req, d, {28'b0, m_st});
    endtask

    initial begin
        #1_000_000;
        bad++; total++;
        $display("FAIL watchdog: got timeout expected completion");
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        for (int t = 0; t < 6; t++) begin
            m_o[t] = 0;
            for (int e = 0; e < 4; e++) begin m_v[t][e] = 0; m_a[t][e] = '0; end
        end
        m_st = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk_stat("R9 status");
        for (int t = 0; t < 6; t++) chk_tab("R9", t);
        chk("R9 fwd", {26'b0, fault_corr, fault_uncorr}, 32'h0);
        rd(6'd3, d); chk("R1 unmapped", d, 32'h0);
        // R1 R2 first SRAM correctable
        ev(3'b001, 3'b000, 16'h0100, 0, 0);
        chk_tab("R2 first", 0);
        chk_stat("R8 status sram corr");
        // R3 duplicate
        ev(3'b001, 3'b000, 16'h0100, 0, 0);
        chk_tab("R3 dup", 0);
        // fill and overflow
        ev(3'b001, 3'b000, 16'h0101, 0, 0);
        ev(3'b001, 3'b000, 16'h0102, 0, 0);
        ev(3'b001, 3'b000, 16'h0103, 0, 0);
        ev(3'b001, 3'b000, 16'h0104, 0, 0);
        chk_tab("R4 overflow", 0);
        rd(6'd8, d); chk("R4 ovf word", d, 32'h0001_000F);
        // R5 clear slot 1, write 0 elsewhere has no effect
        wr(6'd8, 32'h0000_0002);
        chk_tab("R5 clear", 0);
        rd(6'd8, d); chk("R5 ctrl after clear", d, 32'h0001_000D);
        ev(3'b001, 3'b000, 16'h0105, 0, 0);
        rd(6'd33, d); chk("R5 reuse slot", d, 32'h8000_0105);
        chk_tab("R4 sticky", 0);
        // R7 simultaneous, mixed severities
        ev(3'b111, 3'b101, 16'h0200, 16'h0300, 16'h0400);
        chk_tab("R7 sram unc", 1);
        chk_tab("R7 spm corr", 2);
        chk_tab("R7 flash unc", 5);
        rd(6'd0, d); chk("R7 status flash", d, 32'h0000_000D);
        // R8 status updates on duplicate event
        ev(3'b001, 3'b000, 16'h0100, 0, 0);
        rd(6'd0, d); chk("R8 status dup", d, 32'h0000_0008);
        // R1 scratchpad uncorrectable goes to log 3
        ev(3'b010, 3'b010, 16'h0333, 0, 0);
        ev(3'b010, 3'b010, 0, 16'h0333, 0);
        chk_tab("R1 spm unc", 3);
        chk_stat("R8 status spm unc");
        repeat (2) @(negedge clk);
        chk("R6 all pulses seen", 32'(expq.size()), 32'h0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule